// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block holds the mode word that was last programmed into an SDRAM device and, for every read or write burst, produces the column address of each beat in the order the device will use. A controller loads the mode word while the sequencer is idle. It then issues a start request with a 9-bit starting column and a read/write flag. After that it pulls beats one at a time. The decoded CAS latency and an illegal-mode flag are always present on outputs, so the controller can schedule its data path and refuse bad settings.

The beat stream is a valid/ready interface. `beat_valid` is high while a burst is active, and `col` and `beat_last` describe the beat on offer. A beat is consumed only on a clock edge where `beat_ready` is high. While `beat_ready` is low, the offered beat does not change, so back-pressure may last any number of cycles. The burst ends on the edge that consumes a beat flagged `beat_last`. `terminate` marks the beat currently on offer as the last one. Mode, start and terminate are plain control pins with no handshake.

Mode word fields: bits [2:0] burst length, bit 3 burst type, bits [6:4] CAS latency, bits [8:7] operating mode, bit 9 write single-access. Bits 10 and 11 are not decoded.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset the stored mode word is all zeros. `beat_valid` is 0, `mode_illegal` is 1 because CAS code 000 is reserved, and `cas_lat` is 0.
- R2: A `mode_load` pulse while no burst is active captures `mode_word`, and the decoded outputs reflect it from the next cycle on. A `mode_load` while a burst is active is ignored.
- R3: The CAS latency field [6:4] decodes as 001→1, 010→2 and 011→3 on `cas_lat`. Any other code drives `cas_lat` to 0 and sets `mode_illegal`.
- R4: `mode_illegal` is 1 in each of these cases: length field [2:0] is 100, 101 or 110; the CAS code is reserved; bits [8:7] are not 00; or the length field is 111 with bit 3 set. While it is 1, start requests are refused and no beat is produced.
- R5: A `start` is accepted when the sequencer is idle, the mode is legal and `mode_load` is low. The first beat is offered in the next cycle with `col` equal to `start_col`. A `start` while a burst is active is ignored and the running burst continues unchanged.
- R6: When `beat_valid` is 1 and `beat_ready` is 0, `col`, `beat_last` and `beat_valid` hold. The sequence advances one beat per edge with `beat_ready` high.
- R7: Length codes 001, 010 and 011 give 2, 4 and 8 beats with bit 3 = 0 (sequential). The low 1, 2 or 3 column bits count up from the start and wrap inside the aligned block; for example, length 4 from offset 2 gives 2,3,0,1. The last beat carries `beat_last`.
- R8: With bit 3 = 1 (interleaved), the in-block offset of beat i is the start offset XOR i; for example, length 8 from offset 5 gives 5,4,7,6,1,0,3,2.
- R9: Length code 000 gives one beat at `start_col` with `beat_last` set, whatever bit 3 holds.
- R10: Length code 111 (full row) increments the low 8 column bits from the start and wraps from 255 to 0, keeping bit 8. It continues without end, and `beat_last` is 1 only in cycles where `terminate` is 1.
- R11: With bit 9 = 1, a write (`start_write` = 1) produces exactly one beat at `start_col`. A read with the same mode uses the programmed length.
- R12: `terminate` during a fixed-length burst sets `beat_last` on the offered beat, and the burst ends when that beat is consumed.
- R13: For fixed-length bursts, column bits above the aligned block stay constant for the whole burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Load `mode_word` (idle only) |
| mode_word | input | 12 | Mode value to program |
| start | input | 1 | Begin a burst |
| start_col | input | 9 | Starting column |
| start_write | input | 1 | 1 = write burst, 0 = read burst |
| beat_ready | input | 1 | Consumer takes the offered beat |
| terminate | input | 1 | Offered beat is the last one |
| col | output | 9 | Column of the offered beat |
| beat_valid | output | 1 | A beat is on offer |
| beat_last | output | 1 | Offered beat ends the burst |
| cas_lat | output | 2 | Decoded CAS latency, 0 when reserved |
| mode_illegal | output | 1 | Stored mode holds a reserved setting |

## Verification
The assertions assume that `beat_ready`, `terminate`, `start` and `mode_load` are stable around the clock edge. They also assume that `terminate` is only meaningful while a beat is on offer. The bench changes every input at the falling edge. It raises `terminate` only while `beat_valid` is high and drops it once the burst ends. Busy-time start and mode-load pulses are applied deliberately, because the design must ignore them rather than because the assertions forbid them.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Field positions inside the mode word
  localparam int LEN_LSB = 0;
  localparam int BT_BIT  = 3;
  localparam int CAS_LSB = 4;
  localparam int OP_LSB  = 7;
  localparam int WS_BIT  = 9;

  // Shape of one burst: aligned block size (log2), full-row flag, order
  typedef struct packed {
    logic [1:0] blk_log2;
    logic       full_row;
    logic       interleave;
  } sbs_shape_t;

  // Decoded mode word
  typedef struct packed {
    sbs_shape_t shape;
    logic       wr_single;
    logic [1:0] cas;
    logic       illegal;
  } sbs_mode_t;

endpackage

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
  import sbs_pkg::*;
#(
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              idle,
  input  logic [MODE_W-1:0] word,
  output sbs_mode_t         mode
);

  logic [MODE_W-1:0] word_q;
  logic              unused_rsvd;

  always_ff @(posedge clk) begin
    if (!rst_n)
      word_q <= '0;
    else if (load && idle)
      word_q <= word;
  end

  assign unused_rsvd = ^word_q[MODE_W-1:WS_BIT+1];

  always_comb begin
    mode = '0;
    // burst length
    case (word_q[LEN_LSB +: 3])
      3'b000:  mode.shape.blk_log2 = 2'd0;
      3'b001:  mode.shape.blk_log2 = 2'd1;
      3'b010:  mode.shape.blk_log2 = 2'd2;
      3'b011:  mode.shape.blk_log2 = 2'd3;
      3'b111:  mode.shape.full_row = 1'b1;
      default: mode.illegal = 1'b1;
    endcase
    mode.shape.interleave = word_q[BT_BIT];
    // CAS latency
    case (word_q[CAS_LSB +: 3])
      3'b001:  mode.cas = 2'd1;
      3'b010:  mode.cas = 2'd2;
      3'b011:  mode.cas = 2'd3;
      default: begin
        mode.cas     = 2'd0;
        mode.illegal = 1'b1;
      end
    endcase
    if (word_q[OP_LSB +: 2] != 2'b00)
      mode.illegal = 1'b1;
    if (mode.shape.full_row && mode.shape.interleave)
      mode.illegal = 1'b1;
    mode.wr_single = word_q[WS_BIT];
  end

  // R2
  mode_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(mode));

  // R3
  cas_nonzero_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.illegal |-> mode.cas != 2'd0);

endmodule

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl
  import sbs_pkg::*;
#(
  parameter int COL_W     = 9,
  parameter int PAGE_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_write,
  input  logic             mode_load,
  input  sbs_mode_t        mode,
  input  logic             beat_ready,
  input  logic             terminate,
  output logic             active,
  output logic [COL_W-1:0] base,
  output logic [PAGE_LOG2-1:0] idx,
  output sbs_shape_t       shape,
  output logic             beat_last
);

  localparam int IDX_W = PAGE_LOG2;

  logic             start_ok;
  sbs_shape_t       eff_shape;
  logic [IDX_W-1:0] last_idx;
  logic             unused_cas;

  assign unused_cas = ^mode.cas;

  assign start_ok = start && !active && !mode_load && !mode.illegal;

  always_comb begin
    eff_shape = mode.shape;
    if (start_write && mode.wr_single) begin
      eff_shape.blk_log2   = 2'd0;
      eff_shape.full_row   = 1'b0;
      eff_shape.interleave = 1'b0;
    end
  end

  assign last_idx  = IDX_W'((1 << shape.blk_log2) - 1);
  assign beat_last = active && (terminate || (!shape.full_row && idx == last_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      idx    <= '0;
      shape  <= '0;
    end else if (start_ok) begin
      active <= 1'b1;
      base   <= start_col;
      idx    <= '0;
      shape  <= eff_shape;
    end else if (active && beat_ready) begin
      if (beat_last)
        active <= 1'b0;
      else
        idx <= idx + 1'b1;
    end
  end

  // R6
  backpressure_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && !beat_ready |=> active && $stable(idx) && $stable(base));

  // R5
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && start |=> $stable(base));

  // R10
  full_row_no_self_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && shape.full_row && !terminate |=> active);

  // R4
  illegal_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active && mode.illegal |=> !active);

endmodule

// File: rtl/sbs_col_gen.sv
module sbs_col_gen
  import sbs_pkg::*;
#(
  parameter int COL_W        = 9,
  parameter int PAGE_LOG2    = 8,
  parameter int MAX_BLK_LOG2 = 3
) (
  input  logic [COL_W-1:0]     base,
  input  logic [PAGE_LOG2-1:0] idx,
  input  sbs_shape_t           shape,
  output logic [COL_W-1:0]     col
);

  localparam logic [COL_W-1:0] PAGE_MASK = COL_W'((1 << PAGE_LOG2) - 1);

  logic [COL_W-1:0] idx_ext;
  logic [COL_W-1:0] seq_c [MAX_BLK_LOG2+1];
  logic [COL_W-1:0] itl_c [MAX_BLK_LOG2+1];
  logic [COL_W-1:0] row_c;

  assign idx_ext = {{(COL_W-PAGE_LOG2){1'b0}}, idx};

  for (genvar k = 0; k <= MAX_BLK_LOG2; k++) begin : g_blk
    localparam logic [COL_W-1:0] MASK = COL_W'((1 << k) - 1);
    assign seq_c[k] = (base & ~MASK) | ((base + idx_ext) & MASK);
    assign itl_c[k] = (base & ~MASK) | ((base ^ idx_ext) & MASK);
  end

  assign row_c = (base & ~PAGE_MASK) | ((base + idx_ext) & PAGE_MASK);

  always_comb begin
    if (shape.full_row)
      col = row_c;
    else if (shape.interleave)
      col = itl_c[shape.blk_log2];
    else
      col = seq_c[shape.blk_log2];
  end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int MODE_W       = 12,
  parameter int COL_W        = 9,
  parameter int PAGE_LOG2    = 8,
  parameter int MAX_BLK_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              start_write,
  input  logic              beat_ready,
  input  logic              terminate,
  output logic [COL_W-1:0]  col,
  output logic              beat_valid,
  output logic              beat_last,
  output logic [1:0]        cas_lat,
  output logic              mode_illegal
);

  sbs_mode_t            mode;
  sbs_shape_t           shape;
  logic                 active;
  logic [COL_W-1:0]     base;
  logic [PAGE_LOG2-1:0] idx;

  sbs_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mode_load),
    .idle  (!active),
    .word  (mode_word),
    .mode  (mode)
  );

  sbs_burst_ctrl #(.COL_W(COL_W), .PAGE_LOG2(PAGE_LOG2)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_col   (start_col),
    .start_write (start_write),
    .mode_load   (mode_load),
    .mode        (mode),
    .beat_ready  (beat_ready),
    .terminate   (terminate),
    .active      (active),
    .base        (base),
    .idx         (idx),
    .shape       (shape),
    .beat_last   (beat_last)
  );

  sbs_col_gen #(.COL_W(COL_W), .PAGE_LOG2(PAGE_LOG2), .MAX_BLK_LOG2(MAX_BLK_LOG2)) u_col (
    .base  (base),
    .idx   (idx),
    .shape (shape),
    .col   (col)
  );

  assign beat_valid   = active;
  assign cas_lat      = mode.cas;
  assign mode_illegal = mode.illegal;

  // R13
  upper_bits_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !shape.full_row && !(beat_ready && beat_last)
    |=> col[COL_W-1:MAX_BLK_LOG2] == $past(col[COL_W-1:MAX_BLK_LOG2]));

  // R6
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(col));

  // R10
  row_bit8_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !(beat_ready && beat_last) |=> col[COL_W-1] == $past(col[COL_W-1]));

  // R12
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

endmodule

// File: tb/sim_sdram_burst_seq.sv
`timescale 1ns/1ps
module sim_sdram_burst_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_load = 1'b0;
  logic [11:0] mode_word = '0;
  logic        start = 1'b0;
  logic [8:0]  start_col = '0;
  logic        start_write = 1'b0;
  logic        beat_ready = 1'b1;
  logic        terminate = 1'b0;
  logic [8:0]  col;
  logic        beat_valid, beat_last, mode_illegal;
  logic [1:0]  cas_lat;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdram_burst_seq u0 (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
    .start(start), .start_col(start_col), .start_write(start_write),
    .beat_ready(beat_ready), .terminate(terminate), .col(col),
    .beat_valid(beat_valid), .beat_last(beat_last), .cas_lat(cas_lat),
    .mode_illegal(mode_illegal)
  );

  typedef struct packed {
    logic [11:0]         mw;
    logic [8:0]          sc;
    logic                wr;
    logic [3:0]          n;
    logic [1:0]          cas;
    logic [0:7][8:0]     e;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{12'h022, 9'h1A6, 1'b0, 4'd4, 2'd2, {9'h1A6,9'h1A7,9'h1A4,9'h1A5,9'h0,9'h0,9'h0,9'h0}},  // R7
    '{12'h02B, 9'h0F5, 1'b0, 4'd8, 2'd2, {9'h0F5,9'h0F4,9'h0F7,9'h0F6,9'h0F1,9'h0F0,9'h0F3,9'h0F2}}, // R8
    '{12'h021, 9'h133, 1'b0, 4'd2, 2'd2, {9'h133,9'h132,9'h0,9'h0,9'h0,9'h0,9'h0,9'h0}},      // R7
    '{12'h029, 9'h011, 1'b1, 4'd2, 2'd2, {9'h011,9'h010,9'h0,9'h0,9'h0,9'h0,9'h0,9'h0}},      // R8
    '{12'h033, 9'h04E, 1'b0, 4'd8, 2'd3, {9'h04E,9'h04F,9'h048,9'h049,9'h04A,9'h04B,9'h04C,9'h04D}}, // R7
    '{12'h018, 9'h155, 1'b0, 4'd1, 2'd1, {9'h155,9'h0,9'h0,9'h0,9'h0,9'h0,9'h0,9'h0}},        // R9
    '{12'h223, 9'h04E, 1'b1, 4'd1, 2'd2, {9'h04E,9'h0,9'h0,9'h0,9'h0,9'h0,9'h0,9'h0}},        // R11
    '{12'h223, 9'h04E, 1'b0, 4'd8, 2'd2, {9'h04E,9'h04F,9'h048,9'h049,9'h04A,9'h04B,9'h04C,9'h04D}}, // R11
    '{12'h02A, 9'h007, 1'b0, 4'd4, 2'd2, {9'h007,9'h006,9'h005,9'h004,9'h0,9'h0,9'h0,9'h0}}   // R8
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_mode(input logic [11:0] w);
    @(negedge clk);
    mode_load = 1'b1;
    mode_word = w;
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  task automatic kick(input logic [8:0] c, input logic wr);
    start = 1'b1;
    start_col = c;
    start_write = wr;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 valid after reset", beat_valid, 0);
    chk("R1 illegal after reset", mode_illegal, 1);
    chk("R1 cas after reset", cas_lat, 0);

    // R4: start refused while mode illegal
    kick(9'h010, 1'b0);
    #1 chk("R4 no beat when illegal", beat_valid, 0);

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      load_mode(VECS[v].mw);
      #1;
      chk("R2/R3 cas decode", cas_lat, VECS[v].cas);
      chk("R4 legal mode", mode_illegal, 0);
      kick(VECS[v].sc, VECS[v].wr);
      for (int i = 0; i < VECS[v].n; i++) begin
        #1;
        chk("R5 valid", beat_valid, 1);
        chk("R7/R8/R9/R11 col", col, VECS[v].e[i]);
        chk("R7/R9 last", beat_last, (i == VECS[v].n - 1) ? 1 : 0);
        @(negedge clk);
      end
      #1 chk("R7 burst ended", beat_valid, 0);
    end

    // R4 / R3: reserved codes
    load_mode(12'h024); #1 chk("R4 len 100 illegal", mode_illegal, 1);
    load_mode(12'h02F); #1 chk("R4 full row interleaved illegal", mode_illegal, 1);
    load_mode(12'h0A2); #1 chk("R4 op mode illegal", mode_illegal, 1);
    load_mode(12'h042); #1 chk("R3 cas 100 illegal", mode_illegal, 1);
    chk("R3 cas 100 value", cas_lat, 0);
    kick(9'h000, 1'b0);
    #1 chk("R4 start refused", beat_valid, 0);

    // R6: back-pressure
    load_mode(12'h022);
    beat_ready = 1'b0;
    kick(9'h006, 1'b0);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R6 held col", col, 9'h006);
      chk("R6 held valid", beat_valid, 1);
      chk("R6 held last", beat_last, 0);
      @(negedge clk);
    end
    beat_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R6 col after release", col, (i == 0) ? 9'h006 : (i == 1) ? 9'h007 : (i == 2) ? 9'h004 : 9'h005);
      @(negedge clk);
    end
    #1 chk("R6 ended", beat_valid, 0);

    // R5 / R2: start and mode load while busy are ignored
    load_mode(12'h033);
    kick(9'h04E, 1'b0);
    for (int i = 0; i < 8; i++) begin
      #1;
      chk("R5 busy col", col, 9'h048 | ((9'h006 + 9'(i)) & 9'h007));
      if (i == 1) begin
        start = 1'b1; start_col = 9'h000; mode_load = 1'b1; mode_word = 12'h021;
      end else begin
        start = 1'b0; mode_load = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; mode_load = 1'b0;
    #1;
    chk("R5 ended after 8", beat_valid, 0);
    chk("R2 busy load ignored", cas_lat, 3);

    // R10: full row, wraps 255->0 keeping bit 8, ends only on terminate
    load_mode(12'h027);
    kick(9'h1FD, 1'b0);
    for (int i = 0; i < 6; i++) begin
      terminate = (i == 5);
      #1;
      chk("R10 col", col, {1'b1, 8'(8'hFD + i)});
      chk("R10 last", beat_last, (i == 5) ? 1 : 0);
      @(negedge clk);
    end
    terminate = 1'b0;
    #1 chk("R10 ended on terminate", beat_valid, 0);

    // R12: terminate cuts a fixed burst short
    load_mode(12'h023);
    kick(9'h040, 1'b0);
    for (int i = 0; i < 3; i++) begin
      terminate = (i == 2);
      #1;
      chk("R12 col", col, 9'h040 + 9'(i));
      chk("R12 last", beat_last, (i == 2) ? 1 : 0);
      @(negedge clk);
    end
    terminate = 1'b0;
    #1 chk("R12 ended", beat_valid, 0);

    finish_up();
  end

endmodule